// File: doc/BRIEF.md
# Video Memory Random-Access Port Decoder

This block is a clocked behavioural model of the random-access side of a video memory with 4-bit words. The edges of the external strobes reach it as one-cycle event pulses: the row strobe falling, the row strobe rising, the column strobe falling and the write enable falling. Alongside the pulses come the levels of the control pins. At a row event the block samples those levels and decides what kind of cycle is open. Each later column event, or a late write-enable edge, then acts on a small internal array or on one of two internal registers.

There are four write flavours. The first takes its per-bit mask from the data pins in the same cycle. The second reuses a stored mask. The third is unmasked. The fourth is a block write, which copies the colour register into up to four neighbouring columns chosen by a column mask carried on the data pins. Register-load cycles fill either the stored write mask or the colour register. Reads return the addressed word on a registered output, together with a one-cycle valid flag.

Top module: `vram_rand_port`

## Requirements
- R1: After reset the stored write mask is 4'b1111, the colour register is 4'b0000 and `dout_valid` is low. A stored-mask write issued before any mask load therefore changes all four bits.
- R2: If `col_strobe_n` is low when the row strobe falls, the cycle is a refresh. Every column and write-enable event before the next row-strobe rise leaves the array and both registers unchanged, and no read is returned.
- R3: If `xfer_n` is low when the row strobe falls, the cycle is ignored in the same way as in R2.
- R4: If `wen_n`=0 and `func_sel`=0 when the row strobe falls, `din` at that moment becomes the bit mask for this cycle's writes. Mask bit i=1 writes data bit i; mask bit i=0 keeps the stored bit.
- R5: If `wen_n`=0 and `func_sel`=1 when the row strobe falls, the stored write mask is used as the bit mask, and `din` at the row event has no effect.
- R6: If `wen_n`=1 and `func_sel`=0 when the row strobe falls, writes in the cycle are unmasked and change all four bits.
- R7: If `wen_n`=1 and `func_sel`=1 when the row strobe falls, the cycle loads a register. A column event with `func_sel`=0 loads `din` into the stored write mask and leaves the array unchanged.
- R8: In a register-load cycle, a column event with `func_sel`=1 loads `din` into the colour register.
- R9: A write whose column event has `func_sel`=1 is a block write. Column bits [COL_BITS-1:2] select a group of four columns. `din` bit j enables column 4*group+j. Each enabled column receives the colour register under the cycle's bit mask. Disabled columns keep their contents.
- R10: If `wen_n` is low at a column event, the write takes place at that event with `din` as it is then. Otherwise the write takes place at the first write-enable fall that follows within the same column access, with `din` as it is then. There is at most one write per column event.
- R11: A column event with `wen_n`=1 and `func_sel`=0 in an access cycle is a read. `dout` holds the addressed word and `dout_valid` is high in the cycle after the event, and in that cycle only.
- R12: The row is sampled from `addr[ROW_BITS-1:0]` at the row event. The column is sampled from `addr[COL_BITS-1:0]` at each column event. Word index = row*2^COL_BITS + column. Several column events may follow one row event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_strobe_fall | input | 1 | One-cycle pulse: row strobe fell |
| row_strobe_rise | input | 1 | One-cycle pulse: row strobe rose, cycle ends |
| col_strobe_fall | input | 1 | One-cycle pulse: column strobe fell |
| wen_fall | input | 1 | One-cycle pulse: write enable fell |
| col_strobe_n | input | 1 | Column strobe level |
| xfer_n | input | 1 | Transfer-gate level, high for random access |
| wen_n | input | 1 | Write-enable level, active low |
| func_sel | input | 1 | Special-function select level |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 4 | Data pins in: data, bit mask or column mask |
| dout | output | 4 | Read data |
| dout_valid | output | 1 | High for one cycle when `dout` holds read data |

## Verification
Reads are the only result that appears directly at the ports. A read launched by the column pulse at edge k shows up on `dout` and `dout_valid` after edge k. The bench therefore pushes the expected word into the scoreboard while the column pulse is being driven, and the monitor compares at the falling edge that follows. Writes and register loads take effect at the edge that samples their pulse, so the bench observes them only through later reads. Each ignored stimulus is followed by a read of the word it could have changed.

// File: rtl/vram_pkg.sv
package vram_pkg;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned LANES  = 4;

  typedef enum logic [1:0] {
    K_IDLE   = 2'd0,
    K_ACCESS = 2'd1,
    K_LOAD   = 2'd2,
    K_IGNORE = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/vram_cycle_decode.sv
module vram_cycle_decode
  import vram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 4,
  localparam int unsigned ADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_strobe_fall,
  input  logic                row_strobe_rise,
  input  logic                col_strobe_fall,
  input  logic                wen_fall,
  input  logic                col_strobe_n,
  input  logic                xfer_n,
  input  logic                wen_n,
  input  logic                func_sel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   din,
  input  logic [WORD_W-1:0]   stored_mask,
  output cyc_kind_t           kind_q,
  output logic                wr_en,
  output logic                wr_blk,
  output logic [ROW_BITS-1:0] row_q,
  output logic [COL_BITS-1:0] wr_col,
  output logic [WORD_W-1:0]   bit_mask,
  output logic                rd_en,
  output logic [COL_BITS-1:0] rd_col,
  output logic                ld_mask,
  output logic                ld_color
);
  cyc_kind_t           kind_d;
  logic [WORD_W-1:0]   mask_q, mask_d;
  logic [ROW_BITS-1:0] row_d;
  logic [COL_BITS-1:0] col_q, col_d;
  logic                blk_q, blk_d;
  logic                pend_q, pend_d;
  logic                evt;

  assign evt      = row_strobe_fall | row_strobe_rise | col_strobe_fall | wen_fall;
  assign bit_mask = mask_q;
  assign rd_col   = addr[COL_BITS-1:0];

  always_comb begin
    kind_d   = kind_q;
    mask_d   = mask_q;
    row_d    = row_q;
    col_d    = col_q;
    blk_d    = blk_q;
    pend_d   = pend_q;
    wr_en    = 1'b0;
    wr_blk   = blk_q;
    wr_col   = col_q;
    rd_en    = 1'b0;
    ld_mask  = 1'b0;
    ld_color = 1'b0;
    if (row_strobe_fall) begin
      row_d  = addr[ROW_BITS-1:0];
      pend_d = 1'b0;
      if (!col_strobe_n || !xfer_n) begin
        kind_d = K_IGNORE;
      end else if (wen_n && func_sel) begin
        kind_d = K_LOAD;
      end else begin
        kind_d = K_ACCESS;
        if (!wen_n) mask_d = func_sel ? stored_mask : din;
        else        mask_d = '1;
      end
    end else if (row_strobe_rise) begin
      kind_d = K_IDLE;
      pend_d = 1'b0;
    end else if (col_strobe_fall) begin
      if (kind_q == K_ACCESS) begin
        col_d = addr[COL_BITS-1:0];
        blk_d = func_sel;
        if (!wen_n) begin
          wr_en  = 1'b1;
          wr_col = addr[COL_BITS-1:0];
          wr_blk = func_sel;
          pend_d = 1'b0;
        end else begin
          pend_d = 1'b1;
          rd_en  = !func_sel;
        end
      end else if (kind_q == K_LOAD) begin
        ld_mask  = !func_sel;
        ld_color = func_sel;
      end
    end else if (wen_fall && (kind_q == K_ACCESS) && pend_q) begin
      wr_en  = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      mask_q <= '1;
      row_q  <= '0;
      col_q  <= '0;
      blk_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (evt) begin
      kind_q <= kind_d;
      mask_q <= mask_d;
      row_q  <= row_d;
      col_q  <= col_d;
      blk_q  <= blk_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/vram_mask_regs.sv
module vram_mask_regs
  import vram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] wmask_q,
  output logic [WORD_W-1:0] color_q
);
  logic [WORD_W-1:0] wmask_d, color_d;

  always_comb begin
    wmask_d = ld_mask  ? din : wmask_q;
    color_d = ld_color ? din : color_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= '1;
      color_q <= '0;
    end else if (ld_mask || ld_color) begin
      wmask_q <= wmask_d;
      color_q <= color_d;
    end
  end
endmodule

// File: rtl/vram_array.sv
module vram_array
  import vram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_blk,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] wr_col,
  input  logic [WORD_W-1:0]   bit_mask,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [WORD_W-1:0]   color,
  input  logic                rd_en,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [WORD_W-1:0]   dout,
  output logic                dout_valid
);
  localparam int unsigned IDX_W = ROW_BITS + COL_BITS;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned GRP_W = COL_BITS - 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  word_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  lane_idx [LANES];
  logic [WORD_W-1:0] lane_new [LANES];
  logic [WORD_W-1:0] word_new;
  logic [GRP_W-1:0]  grp;

  assign word_idx = {row, wr_col};
  assign rd_idx   = {row, rd_col};
  assign grp      = wr_col[COL_BITS-1:2];
  assign word_new = (mem[word_idx] & ~bit_mask) | (wr_data & bit_mask);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_idx[j] = {row, grp, 2'(j)};
    assign lane_new[j] = (mem[lane_idx[j]] & ~bit_mask) | (color & bit_mask);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_blk) begin
        for (int j = 0; j < LANES; j++) begin
          if (wr_data[j]) mem[lane_idx[j]] <= lane_new[j];
        end
      end else begin
        mem[word_idx] <= word_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= rd_en;
      if (rd_en) dout <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/vram_rand_port.sv
module vram_rand_port
  import vram_pkg::*;
#(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 4,
  localparam int unsigned ADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_strobe_fall,
  input  logic              row_strobe_rise,
  input  logic              col_strobe_fall,
  input  logic              wen_fall,
  input  logic              col_strobe_n,
  input  logic              xfer_n,
  input  logic              wen_n,
  input  logic              func_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        din,
  output logic [3:0]        dout,
  output logic              dout_valid
);
  cyc_kind_t           kind_q;
  logic                wr_en, wr_blk, rd_en, ld_mask, ld_color;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] wr_col, rd_col;
  logic [WORD_W-1:0]   bit_mask, wmask_q, color_q;

  vram_cycle_decode #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_decode (
    .clk(clk), .rst_n(rst_n),
    .row_strobe_fall(row_strobe_fall), .row_strobe_rise(row_strobe_rise),
    .col_strobe_fall(col_strobe_fall), .wen_fall(wen_fall),
    .col_strobe_n(col_strobe_n), .xfer_n(xfer_n), .wen_n(wen_n),
    .func_sel(func_sel), .addr(addr), .din(din), .stored_mask(wmask_q),
    .kind_q(kind_q), .wr_en(wr_en), .wr_blk(wr_blk), .row_q(row_q),
    .wr_col(wr_col), .bit_mask(bit_mask), .rd_en(rd_en), .rd_col(rd_col),
    .ld_mask(ld_mask), .ld_color(ld_color)
  );

  vram_mask_regs i_regs (
    .clk(clk), .rst_n(rst_n), .ld_mask(ld_mask), .ld_color(ld_color),
    .din(din), .wmask_q(wmask_q), .color_q(color_q)
  );

  vram_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .row(row_q),
    .wr_col(wr_col), .bit_mask(bit_mask), .wr_data(din), .color(color_q),
    .rd_en(rd_en), .rd_col(rd_col), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/vram_rand_port_chk.sv
module vram_rand_port_chk
  import vram_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input cyc_kind_t         kind_q,
  input logic              wr_en,
  input logic              rd_en,
  input logic              ld_mask,
  input logic              ld_color,
  input logic              dout_valid,
  input logic [WORD_W-1:0] wmask_q,
  input logic [WORD_W-1:0] color_q
);
  a_r11_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dout_valid);
  a_r11_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(rd_en));
  a_r2_ignored_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_IGNORE) |-> !(wr_en || rd_en || ld_mask || ld_color));
  a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mask |=> $stable(wmask_q));
  a_r8_color_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_color |=> $stable(color_q));
  a_r10_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en, ld_mask, ld_color}));
endmodule

bind vram_rand_port vram_rand_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .kind_q(kind_q), .wr_en(wr_en), .rd_en(rd_en),
  .ld_mask(ld_mask), .ld_color(ld_color), .dout_valid(dout_valid),
  .wmask_q(wmask_q), .color_q(color_q)
);

// File: tb/test_vram_rand_port.sv
`timescale 1ns/1ps
module test_vram_rand_port;
  localparam int ROW_BITS = 3;
  localparam int COL_BITS = 4;
  localparam int ADDR_W   = 4;
  localparam int COLS     = 1 << COL_BITS;
  localparam int WORDS    = 1 << (ROW_BITS + COL_BITS);
  localparam int MD_LU = 0, MD_PW = 1, MD_NM = 2;

  logic clk, rst_n;
  logic row_strobe_fall, row_strobe_rise, col_strobe_fall, wen_fall;
  logic col_strobe_n, xfer_n, wen_n, func_sel;
  logic [ADDR_W-1:0] addr;
  logic [3:0] din, dout;
  logic dout_valid;

  int checks = 0;
  int errors = 0;
  logic [3:0] shadow [WORDS];
  logic [3:0] tb_wmask, tb_color;
  logic [3:0] exp_q [$];
  string tag_q [$];

  vram_rand_port #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_vram_rand_port (
    .clk(clk), .rst_n(rst_n), .row_strobe_fall(row_strobe_fall),
    .row_strobe_rise(row_strobe_rise), .col_strobe_fall(col_strobe_fall),
    .wen_fall(wen_fall), .col_strobe_n(col_strobe_n), .xfer_n(xfer_n),
    .wen_n(wen_n), .func_sel(func_sel), .addr(addr), .din(din),
    .dout(dout), .dout_valid(dout_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int widx(input int row, input int col);
    return row * COLS + col;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && dout_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual unexpected valid expected none");
      end else begin
        check(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  task automatic row_ev(input logic cs, input logic xf, input logic we,
                        input logic fs, input int row, input logic [3:0] d);
    @(negedge clk);
    col_strobe_n = cs; xfer_n = xf; wen_n = we; func_sel = fs;
    addr = ADDR_W'(row); din = d; row_strobe_fall = 1'b1;
    @(negedge clk);
    row_strobe_fall = 1'b0;
  endtask

  task automatic col_ev(input logic we, input logic fs, input int col, input logic [3:0] d);
    @(negedge clk);
    col_strobe_n = 1'b0; wen_n = we; func_sel = fs; addr = ADDR_W'(col);
    din = d; col_strobe_fall = 1'b1;
    @(negedge clk);
    col_strobe_fall = 1'b0;
  endtask

  task automatic read_ev(input int row, input int col, input string req);
    @(negedge clk);
    col_strobe_n = 1'b0; wen_n = 1'b1; func_sel = 1'b0; addr = ADDR_W'(col);
    din = 4'h0; col_strobe_fall = 1'b1;
    exp_q.push_back(shadow[widx(row, col)]);
    tag_q.push_back(req);
    @(negedge clk);
    col_strobe_fall = 1'b0;
  endtask

  task automatic we_ev(input logic [3:0] d);
    @(negedge clk);
    wen_n = 1'b0; din = d; wen_fall = 1'b1;
    @(negedge clk);
    wen_fall = 1'b0;
  endtask

  task automatic end_ev();
    @(negedge clk);
    row_strobe_rise = 1'b1;
    @(negedge clk);
    row_strobe_rise = 1'b0; col_strobe_n = 1'b1; wen_n = 1'b1; xfer_n = 1'b1;
  endtask

  function automatic logic [3:0] mode_mask(input int md, input logic [3:0] rmask);
    if (md == MD_LU) return rmask;
    if (md == MD_PW) return tb_wmask;
    return 4'hF;
  endfunction

  task automatic do_write(input int md, input int row, input int col,
                          input logic [3:0] d, input logic [3:0] rmask);
    logic [3:0] m;
    m = mode_mask(md, rmask);
    row_ev(1'b1, 1'b1, md == MD_NM, md == MD_PW, row, rmask);
    col_ev(1'b0, 1'b0, col, d);
    shadow[widx(row, col)] = (shadow[widx(row, col)] & ~m) | (d & m);
    end_ev();
  endtask

  task automatic do_block(input int md, input int row, input int col,
                          input logic [3:0] cmask, input logic [3:0] rmask);
    logic [3:0] m;
    int base;
    m = mode_mask(md, rmask);
    row_ev(1'b1, 1'b1, md == MD_NM, md == MD_PW, row, rmask);
    col_ev(1'b0, 1'b1, col, cmask);
    base = (col / 4) * 4;
    for (int j = 0; j < 4; j++) begin
      if (cmask[j])
        shadow[widx(row, base + j)] = (shadow[widx(row, base + j)] & ~m) | (tb_color & m);
    end
    end_ev();
  endtask

  task automatic do_load(input logic to_color, input logic [3:0] d);
    row_ev(1'b1, 1'b1, 1'b1, 1'b1, 0, 4'h0);
    col_ev(1'b1, to_color, 0, d);
    if (to_color) tb_color = d; else tb_wmask = d;
    end_ev();
  endtask

  task automatic do_read(input int row, input int col, input string req);
    row_ev(1'b1, 1'b1, 1'b1, 1'b0, row, 4'h0);
    read_ev(row, col, req);
    end_ev();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still busy expected finished (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    row_strobe_fall = 1'b0; row_strobe_rise = 1'b0;
    col_strobe_fall = 1'b0; wen_fall = 1'b0;
    col_strobe_n = 1'b1; xfer_n = 1'b1; wen_n = 1'b1; func_sel = 1'b0;
    addr = '0; din = 4'h0;
    tb_wmask = 4'hF; tb_color = 4'h0;
    repeat (4) @(negedge clk);
    check("R1", {3'b000, dout_valid}, 4'h0);
    rst_n = 1'b1;

    // fill every word unmasked (R6, R12)
    for (int i = 0; i < WORDS; i++) do_write(MD_NM, i / COLS, i % COLS, 4'((i * 7) ^ 5), 4'h0);
    do_read(0, 0, "R6");
    do_read(3, 9, "R12");
    do_read(7, 15, "R12");

    // R1: stored mask resets to all ones
    do_write(MD_PW, 1, 2, 4'hA, 4'h0);
    do_read(1, 2, "R1");
    // R1: colour resets to zero, shown by an unmasked block write
    do_block(MD_NM, 1, 4, 4'b0001, 4'h0);
    do_read(1, 4, "R1");

    // R4: mask taken from the data pins at the row event
    do_write(MD_NM, 2, 3, 4'h0, 4'h0);
    do_write(MD_LU, 2, 3, 4'hF, 4'b0101);
    do_read(2, 3, "R4");

    // R7: load stored mask, array untouched
    do_load(1'b0, 4'b0011);
    do_read(2, 3, "R7");
    // R5: stored mask used, row-event data ignored
    do_write(MD_PW, 2, 5, 4'h0, 4'b1100);
    do_read(2, 5, "R5");

    // R8 + R9: colour load and block writes
    do_load(1'b1, 4'b1010);
    do_block(MD_NM, 4, 6, 4'b1001, 4'h0);
    for (int c = 4; c < 8; c++) do_read(4, c, "R9");
    do_read(4, 4, "R8");
    do_block(MD_LU, 5, 13, 4'b0110, 4'b0110);
    for (int c = 12; c < 16; c++) do_read(5, c, "R9");
    do_block(MD_PW, 6, 0, 4'b1111, 4'h0);
    for (int c = 0; c < 4; c++) do_read(6, c, "R9");

    // R10 + R11: read-modify-write with late write enable
    row_ev(1'b1, 1'b1, 1'b1, 1'b0, 3, 4'h0);
    read_ev(3, 7, "R11");
    we_ev(4'h6);
    shadow[widx(3, 7)] = 4'h6;
    end_ev();
    do_read(3, 7, "R10");
    // R10: early write, later write-enable edge does nothing
    row_ev(1'b1, 1'b1, 1'b1, 1'b0, 3, 4'h0);
    col_ev(1'b0, 1'b0, 8, 4'h1);
    we_ev(4'h9);
    shadow[widx(3, 8)] = 4'h1;
    end_ev();
    do_read(3, 8, "R10");

    // R12: two column events in one row cycle
    row_ev(1'b1, 1'b1, 1'b1, 1'b0, 7, 4'h0);
    col_ev(1'b0, 1'b0, 1, 4'hC);
    col_ev(1'b0, 1'b0, 2, 4'h3);
    shadow[widx(7, 1)] = 4'hC;
    shadow[widx(7, 2)] = 4'h3;
    end_ev();
    do_read(7, 1, "R12");
    do_read(7, 2, "R12");

    // R2: refresh cycle ignores everything
    row_ev(1'b0, 1'b1, 1'b0, 1'b0, 0, 4'hF);
    col_ev(1'b0, 1'b0, 0, 4'hE);
    we_ev(4'hD);
    col_ev(1'b1, 1'b0, 1, 4'h0);
    end_ev();
    do_read(0, 0, "R2");
    do_read(0, 1, "R2");

    // R3: transfer-gate low ignores the cycle, including register loads
    row_ev(1'b1, 1'b0, 1'b1, 1'b1, 0, 4'h0);
    col_ev(1'b1, 1'b1, 0, 4'h5);
    end_ev();
    do_block(MD_NM, 0, 0, 4'b0100, 4'h0);
    do_read(0, 2, "R3");
    row_ev(1'b1, 1'b0, 1'b0, 1'b0, 0, 4'hF);
    col_ev(1'b0, 1'b0, 3, 4'hB);
    end_ev();
    do_read(0, 3, "R3");

    repeat (6) @(negedge clk);
    check("R11", 4'(exp_q.size()), 4'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule